// File: doc/BRIEF.md
# Transfer Controller Activation Router

This block sits between a set of peripheral interrupt sources and a data-transfer engine. Each source raises a pending flag. A per-source routing mask decides where that flag goes. With its mask bit clear, the flag is passed to the CPU as an interrupt request. With its mask bit set, the flag becomes a candidate to start a transfer job.

The router picks one candidate at a time with a fixed priority and issues a one-cycle activation strobe. The strobe carries the job's vector number and the descriptor table address for that vector. The router then waits for the engine to report the end of the job. At that point it pulses one of two clear strobes back to the winning source. The first clears the source's pending flag. The second clears the source's mask bit, so that later requests from that source go to the CPU instead.

Software can also start a job through an 8-bit trigger register. Bit 7 is a start bit that software can only set. Bits 6..0 hold the vector number. The vector field is frozen while the start bit is set. Whether the start bit clears itself at the end of the job depends on two engine flags: chain-disable and count-exhausted.

Top module: `xfer_act_router`

## Requirements
- R1: After reset, the trigger register is zero and all of these outputs are 0: the activation strobe, the software-end interrupt, and both clear strobes.
- R2: `cpu_irq[i]` is 1 exactly when `req_flag[i]` is 1 and `xfer_mask[i]` is 0. A source whose mask bit is 1 never reaches the CPU.
- R3: When several jobs are waiting, the lowest-numbered hardware source with both its flag and its mask bit set wins. A pending software trigger is served only when no such hardware source is waiting.
- R4: Hardware source i uses vector `VEC_BASE + i` (default 0x20 + i). The software trigger uses the register's vector field. `act_addr` equals 0x0400 + 2 × `act_vec` (for example, vector 0x10 gives 0x0420).
- R5: `act_stb` is high for exactly one cycle. No further activation is issued until the engine reports a final completion. The next activation comes no earlier than the clock edge after the completion cycle.
- R6: A final completion (`eng_done`=1, `eng_chain_more`=0) of a hardware job with `eng_disel`=0 and `eng_cnt_zero`=0 pulses `flag_clr` for that source only, in the same cycle.
- R7: A final completion of a hardware job with `eng_disel`=1 or `eng_cnt_zero`=1 pulses `mask_clr` for that source instead. `flag_clr` stays 0.
- R8: `eng_done` with `eng_chain_more`=1 is not a final completion. It produces no clear strobe and keeps the router busy.
- R9: Register writes (`sw_wr`, 8-bit `sw_wdata`) with bit 7 = 1 set the start bit. A write with bit 7 = 0 leaves the start bit unchanged unless the software-end interrupt is pending.
- R10: Bits 6..0 of a write update the vector field only if the start bit was 0 before that write.
- R11: If a software job ends with `eng_disel`=0 and `eng_cnt_zero`=0, the start bit clears. No software-end interrupt is raised and no new software activation follows.
- R12: If a software job ends with `eng_disel`=1 or `eng_cnt_zero`=1, the start bit stays set and `sw_end_irq` rises. The trigger does not start another job.
- R13: While `sw_end_irq` is 1, a write with bit 7 = 0 clears both the start bit and `sw_end_irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_flag | input | NSRC | Pending request flags from the sources |
| xfer_mask | input | NSRC | Routing mask; 1 sends the source to the transfer engine |
| sw_wr | input | 1 | Trigger register write strobe |
| sw_wdata | input | VEC_W+1 | Write data: bit 7 is the start bit, bits 6..0 are the vector |
| eng_done | input | 1 | Engine finished a transfer step |
| eng_chain_more | input | 1 | With `eng_done`, more chained steps follow |
| eng_disel | input | 1 | Chain-disable flag of the finished job |
| eng_cnt_zero | input | 1 | Transfer count of the finished job ran out |
| act_stb | output | 1 | One-cycle activation strobe |
| act_vec | output | VEC_W | Vector number of the activation |
| act_addr | output | ADDR_W | Descriptor table address of the activation |
| cpu_irq | output | NSRC | Requests passed to the CPU |
| flag_clr | output | NSRC | Clear strobe for a source's pending flag |
| mask_clr | output | NSRC | Clear strobe for a source's mask bit |
| sw_end_irq | output | 1 | Software-transfer-end interrupt to the CPU |

## Verification
The assertions check, on every cycle, the invariants that hold regardless of history:
- the activation strobe never lasts two cycles;
- at most one clear strobe fires, and only one kind per completion;
- the end interrupt only exists while the start bit is held;
- the vector field never changes while the start bit stays set.

Priority order, vector-to-address mapping, the choice between flag and mask clearing, and the start-bit outcome for each pair of engine flags all depend on stimulus order. Only the bench's scenarios show these. Examples are a software trigger queued behind two hardware jobs, a chained completion, and an acknowledge write after the end interrupt.

// File: rtl/xfer_act_router.sv
module xfer_act_router #(
  parameter int NSRC = 8,
  parameter int VEC_W = 7,
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] TBL_BASE = 16'h0400,
  parameter logic [VEC_W-1:0] VEC_BASE = 7'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req_flag,
  input  logic [NSRC-1:0]   xfer_mask,
  input  logic              sw_wr,
  input  logic [VEC_W:0]    sw_wdata,
  input  logic              eng_done,
  input  logic              eng_chain_more,
  input  logic              eng_disel,
  input  logic              eng_cnt_zero,
  output logic              act_stb,
  output logic [VEC_W-1:0]  act_vec,
  output logic [ADDR_W-1:0] act_addr,
  output logic [NSRC-1:0]   cpu_irq,
  output logic [NSRC-1:0]   flag_clr,
  output logic [NSRC-1:0]   mask_clr,
  output logic              sw_end_irq
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic             swen_q, swend_q, busy_q, own_sw_q, stb_q;
  logic [VEC_W-1:0] swvec_q, vec_q;
  logic [IDX_W-1:0] own_q, pick;
  logic [NSRC-1:0]  hit, own_oh;
  logic             hw_any, sw_req, fin, hold_end;

  assign hit      = req_flag & xfer_mask;
  assign hw_any   = |hit;
  assign sw_req   = swen_q & ~swend_q;
  assign fin      = busy_q & eng_done & ~eng_chain_more;
  assign hold_end = eng_disel | eng_cnt_zero;
  assign own_oh   = {{(NSRC-1){1'b0}}, 1'b1} << own_q;

  always_comb begin
    pick = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (hit[i]) pick = IDX_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      stb_q    <= 1'b0;
      own_sw_q <= 1'b0;
      own_q    <= '0;
      vec_q    <= '0;
    end else begin
      stb_q <= 1'b0;
      if (fin) begin
        busy_q <= 1'b0;
      end else if (!busy_q && (hw_any || sw_req)) begin
        busy_q   <= 1'b1;
        stb_q    <= 1'b1;
        own_sw_q <= ~hw_any;
        own_q    <= pick;
        vec_q    <= hw_any ? VEC_BASE + VEC_W'(pick) : swvec_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swen_q  <= 1'b0;
      swend_q <= 1'b0;
      swvec_q <= '0;
    end else begin
      if (fin && own_sw_q) begin
        if (hold_end) swend_q <= 1'b1;
        else          swen_q  <= 1'b0;
      end
      if (sw_wr) begin
        if (sw_wdata[VEC_W]) begin
          swen_q <= 1'b1;
        end else if (swend_q) begin
          swen_q  <= 1'b0;
          swend_q <= 1'b0;
        end
        if (!swen_q) swvec_q <= sw_wdata[VEC_W-1:0];
      end
    end
  end

  assign act_stb    = stb_q;
  assign act_vec    = vec_q;
  assign act_addr   = TBL_BASE + (ADDR_W'(vec_q) << 1);
  assign cpu_irq    = req_flag & ~xfer_mask;
  assign flag_clr   = (fin && !own_sw_q && !hold_end) ? own_oh : '0;
  assign mask_clr   = (fin && !own_sw_q &&  hold_end) ? own_oh : '0;
  assign sw_end_irq = swend_q;

  // R5
  stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_stb |=> !act_stb);

  // R7
  clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flag_clr | mask_clr) && ((flag_clr & mask_clr) == '0));

  // R12
  end_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_end_irq |-> swen_q);

  // R10
  vec_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swen_q && $past(swen_q)) |-> $stable(swvec_q));

  // R8
  chain_noclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && eng_chain_more) |-> ((flag_clr | mask_clr) == '0));
endmodule

// File: tb/tb_xfer_act_router.sv
module tb_xfer_act_router;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] req_flag = '0, xfer_mask = '0;
  logic       sw_wr = 1'b0;
  logic [7:0] sw_wdata = '0;
  logic       eng_done = 1'b0, eng_chain_more = 1'b0, eng_disel = 1'b0, eng_cnt_zero = 1'b0;
  logic       act_stb, sw_end_irq;
  logic [6:0] act_vec;
  logic [15:0] act_addr;
  logic [N-1:0] cpu_irq, flag_clr, mask_clr;

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  xfer_act_router dut (
    .clk(clk), .rst_n(rst_n), .req_flag(req_flag), .xfer_mask(xfer_mask),
    .sw_wr(sw_wr), .sw_wdata(sw_wdata), .eng_done(eng_done),
    .eng_chain_more(eng_chain_more), .eng_disel(eng_disel), .eng_cnt_zero(eng_cnt_zero),
    .act_stb(act_stb), .act_vec(act_vec), .act_addr(act_addr), .cpu_irq(cpu_irq),
    .flag_clr(flag_clr), .mask_clr(mask_clr), .sw_end_irq(sw_end_irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  // {flag, mask, expected vector (7F = no activation)}
  localparam int NV = 6;
  localparam logic [22:0] VECS [NV] = '{
    {8'h01, 8'h01, 7'h20},
    {8'h0C, 8'h0C, 7'h22},
    {8'hF0, 8'hA0, 7'h25},
    {8'h80, 8'h80, 7'h27},
    {8'h06, 8'h00, 7'h7F},
    {8'hFF, 8'h81, 7'h20}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic eq(input string req, input string what, input longint act, input longint exp);
    chk(act == exp, req, what, act, exp);
  endtask

  task automatic wr(input logic [7:0] d);
    sw_wr = 1'b1; sw_wdata = d;
    @(negedge clk);
    sw_wr = 1'b0;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    eq("R1", "act_stb", act_stb, 0);
    eq("R1", "sw_end_irq", sw_end_irq, 0);
    eq("R1", "clr", {flag_clr, mask_clr}, 0);
    eq("R1", "act_vec", act_vec, 0);

    for (int k = 0; k < NV; k++) begin
      logic [7:0] f, m; logic [6:0] ev;
      {f, m, ev} = VECS[k];
      req_flag = f; xfer_mask = m;
      #1 eq("R2", "cpu_irq", cpu_irq, f & ~m);
      @(negedge clk);
      if (ev == 7'h7F) begin
        eq("R3", "no act", act_stb, 0);
      end else begin
        eq("R3", "act_stb", act_stb, 1);
        eq("R4", "act_vec", act_vec, ev);
        eq("R4", "act_addr", act_addr, 16'h0400 + 2 * ev);
        eng_done = 1'b1;
        #1 eq("R6", "flag_clr", flag_clr, 8'h1 << (ev - 7'h20));
        eq("R6", "mask_clr", mask_clr, 0);
        @(negedge clk);
        eng_done = 1'b0;
        eq("R5", "no act in finish", act_stb, 0);
      end
      req_flag = '0; xfer_mask = '0;
      @(negedge clk);
    end

    // R9 / R10: write with start bit 0 sets vector, no activation
    wr(8'h03);
    @(negedge clk); eq("R9", "no act after bit7=0", act_stb, 0);
    @(negedge clk); eq("R9", "no act later", act_stb, 0);

    // hardware job 2 busy; queue software trigger and try to alter it
    req_flag = 8'h24; xfer_mask = 8'h24;
    @(negedge clk);
    eq("R4", "hw2 vec", act_vec, 7'h22);
    wr(8'h85);
    eq("R5", "held while busy", act_stb, 0);
    wr(8'h13);
    wr(8'h93);
    eng_done = 1'b1;
    #1 eq("R6", "flag_clr src2", flag_clr, 8'h04);
    @(negedge clk);
    eng_done = 1'b0; req_flag = 8'h20;
    eq("R5", "no act in finish", act_stb, 0);
    @(negedge clk);
    eq("R3", "hw beats sw", act_stb, 1);
    eq("R3", "hw5 vec", act_vec, 7'h25);
    // R8 chain step
    eng_done = 1'b1; eng_chain_more = 1'b1;
    #1 eq("R8", "no clr on chain", {flag_clr, mask_clr}, 0);
    @(negedge clk);
    eng_done = 1'b0; eng_chain_more = 1'b0;
    @(negedge clk);
    eq("R8", "still busy", act_stb, 0);
    // R7 end with chain-disable
    eng_done = 1'b1; eng_disel = 1'b1;
    #1 eq("R7", "mask_clr", mask_clr, 8'h20);
    eq("R7", "flag_clr", flag_clr, 0);
    @(negedge clk);
    eng_done = 1'b0; eng_disel = 1'b0; xfer_mask = 8'h04;
    #1 eq("R2", "irq after mask clear", cpu_irq, 8'h20);
    @(negedge clk);
    eq("R10", "sw act", act_stb, 1);
    eq("R10", "locked vec", act_vec, 7'h05);
    eq("R4", "sw addr", act_addr, 16'h040A);
    // R11 normal end of software job
    eng_done = 1'b1;
    #1 eq("R11", "no hw clr", {flag_clr, mask_clr}, 0);
    @(negedge clk);
    eng_done = 1'b0; req_flag = '0; xfer_mask = '0;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      eq("R11", "no re-act", act_stb, 0);
      eq("R11", "no end irq", sw_end_irq, 0);
    end

    // R12 end with count exhausted
    wr(8'h86);
    @(negedge clk);
    eq("R12", "sw act", act_stb, 1);
    eq("R12", "vec", act_vec, 7'h06);
    eng_done = 1'b1; eng_cnt_zero = 1'b1;
    @(negedge clk);
    eng_done = 1'b0; eng_cnt_zero = 1'b0;
    eq("R12", "end irq", sw_end_irq, 1);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      eq("R12", "no re-act", act_stb, 0);
    end

    // R13 acknowledge
    wr(8'h15);
    eq("R13", "end irq cleared", sw_end_irq, 0);
    @(negedge clk); eq("R13", "start bit cleared", act_stb, 0);
    wr(8'h87);
    @(negedge clk);
    eq("R13", "re-trigger", act_stb, 1);
    eq("R10", "vec writable again", act_vec, 7'h07);
    eq("R4", "addr", act_addr, 16'h040E);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
    @(negedge clk);
    summary();
  end
endmodule